// File: doc/BRIEF.md
# PCI Configuration Command and Status Register Pair

This block holds the two 16-bit halves of the configuration DWORD at offset 0x04 of a PCI function: the command register in the low half and the status register in the high half. Software reaches them through configuration reads and writes qualified by byte enables. The bus engine feeds it single-cycle event pulses. These cover a detected parity error, a signalled or received target abort, a received master abort, a request to signal a system error, and a data parity error seen while acting as master. The engine also presents decoded special-cycle messages.

The command half provides the enable bits the rest of the interface needs: memory write-and-invalidate, parity response, system-error drive and special-cycle response. The block gates the raw parity and system-error conditions through these enables. The status half records bus events in sticky bits that software clears by writing ones. A small power-state machine has two states, ACTIVE and LOW_POWER. It takes one transition, ACTIVE to LOW_POWER (named "shutdown accepted"), when a shutdown broadcast arrives while special cycles are enabled. In LOW_POWER the low-power request is raised and held until reset. Reset is the only way back to ACTIVE.

Top module: `pci_cmdstat_regs`

## Requirements
- R1: After reset the command half reads 0x0000 and the low-power request is 0. The status half reads only its constant bits, which is 0x0280 with the default parameters.
- R2: A write with `cfg_wr` high updates command bits 3, 4 and 6 only when `cfg_be[0]` is 1, and bit 8 only when `cfg_be[1]` is 1. `cfg_rdata[15:0]` returns the command half and `cfg_rdata[31:16]` returns the status half.
- R3: Command bits 0-2, 5, 7 and 9-15 always read 0, whatever is written to them.
- R4: `spcyc_en`, `mwi_en`, `perr_resp_en` and `serr_en` follow command bits 3, 4, 6 and 8. The master must use plain memory writes while `mwi_en` is 0.
- R5: `perr_out` is `ev_perr` gated by command bit 6, in the same cycle. Status bit 15 is set one edge after any `ev_perr` pulse, whatever the value of bit 6.
- R6: Status bit 8 is set one edge after `ev_dperr_master`, but only while command bit 6 is 1.
- R7: `serr_out` is `ev_serr_req` gated by command bit 8, in the same cycle. Status bit 14 is set only when `serr_out` is driven.
- R8: Status bits 13, 12 and 11 are set one edge after `ev_mabort_rcv`, `ev_tabort_rcv` and `ev_tabort_sig` respectively.
- R9: A write with `cfg_be[3]` = 1 clears each sticky status bit (15, 14, 13, 12, 11, 8) whose data bit at position 16 plus the status bit number is 1. Zero data bits, or `cfg_be[3]` = 0, leave the bits unchanged. Software can never set a status bit.
- R10: When an event and a clearing write hit the same status bit in the same cycle, the bit ends set.
- R11: Status bits 10:9 return the DEVSEL timing parameter (00 fast, 01 medium, 10 slow; default 01). Bit 7 returns the fast back-to-back capability parameter (default 1). Bits 6:0 read 0. None of these bits is writable.
- R12: The power machine moves from ACTIVE to LOW_POWER only when `sc_valid` is high, `sc_msg` equals 0x0000 (shutdown) and command bit 3 is 1. Any other message, or bit 3 at 0, is ignored. LOW_POWER drives `low_power_req` high and is left only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write to DWORD 0x04 |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Status in [31:16], command in [15:0] |
| ev_perr | input | 1 | Parity error detected |
| ev_serr_req | input | 1 | System-error condition |
| ev_mabort_rcv | input | 1 | Master abort received |
| ev_tabort_rcv | input | 1 | Target abort received |
| ev_tabort_sig | input | 1 | Target abort signalled |
| ev_dperr_master | input | 1 | Data parity error as master |
| sc_valid | input | 1 | Special-cycle message valid |
| sc_msg | input | 16 | Special-cycle message code |
| spcyc_en | output | 1 | Special-cycle response enable |
| mwi_en | output | 1 | Write-and-invalidate enable |
| perr_resp_en | output | 1 | Parity response enable |
| serr_en | output | 1 | System-error drive enable |
| perr_out | output | 1 | Gated parity response |
| serr_out | output | 1 | Gated system-error request |
| low_power_req | output | 1 | Low-power mode request |

## Verification
Every byte-enable value is tried with all-ones, all-zeros and two alternating data patterns. This separates the per-byte qualification of the writable command bits from the hardwired zero bits. All 64 combinations of the six event pulses are applied under each of the four settings of the parity-response and system-error enables, each after a full clear. This distinguishes ungated bits from gated ones and shows that no event leaks into a neighbouring bit. Clearing writes are tried with a single one bit, with all zeros, with the top byte disabled, and in the same cycle as an event, which separates write-1-to-clear from plain write and shows the set-wins rule. Special-cycle messages 0x0001 to 0x0008 and the shutdown code are sent with special cycles both disabled and enabled, which tells the one accepted transition from the ignored ones.

// File: rtl/pci_cs_pkg.sv
package pci_cs_pkg;
    // command bit positions
    localparam int CMD_SPCYC = 3;
    localparam int CMD_MWI   = 4;
    localparam int CMD_PERR  = 6;
    localparam int CMD_SERR  = 8;

    // sticky status positions inside the upper status byte (bit 8 + index)
    localparam int SH_DPD = 0;  // status bit 8
    localparam int SH_STA = 3;  // status bit 11
    localparam int SH_RTA = 4;  // status bit 12
    localparam int SH_RMA = 5;  // status bit 13
    localparam int SH_SSE = 6;  // status bit 14
    localparam int SH_DPE = 7;  // status bit 15

    typedef enum logic [0:0] {
        PWR_ACTIVE = 1'b0,
        PWR_LOW    = 1'b1
    } pwr_state_e;
endpackage

// File: rtl/pci_cs_cmd_reg.sv
module pci_cs_cmd_reg
    import pci_cs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  be,
    input  logic [15:0] wdata,
    output logic [15:0] cmd
);
    logic spc_q, mwi_q, perr_q, serr_q;
    logic unused_wdata;

    assign unused_wdata = ^{wdata[15:9], wdata[7], wdata[5], wdata[2:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spc_q  <= 1'b0;
            mwi_q  <= 1'b0;
            perr_q <= 1'b0;
            serr_q <= 1'b0;
        end else if (wr_en) begin
            if (be[0]) begin
                spc_q  <= wdata[CMD_SPCYC];
                mwi_q  <= wdata[CMD_MWI];
                perr_q <= wdata[CMD_PERR];
            end
            if (be[1]) begin
                serr_q <= wdata[CMD_SERR];
            end
        end
    end

    always_comb begin
        cmd            = '0;
        cmd[CMD_SPCYC] = spc_q;
        cmd[CMD_MWI]   = mwi_q;
        cmd[CMD_PERR]  = perr_q;
        cmd[CMD_SERR]  = serr_q;
    end

    // R2: an unselected byte keeps its bits
    p_be1_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !be[1]) |=> $stable(cmd[CMD_SERR]));
    p_be0_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !be[0]) |=> $stable(cmd[7:0]));
    // R2: no write, no change
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cmd));
endmodule

// File: rtl/pci_cs_status_reg.sv
module pci_cs_status_reg
    import pci_cs_pkg::*;
#(
    parameter logic [1:0] DEVSEL_TIMING = 2'b01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_en,
    input  logic [7:0] wdata,
    input  logic [7:0] set_in,
    output logic [7:0] stat_hi
);
    localparam logic [7:0] W1C_MASK = 8'b1111_1001;
    localparam logic [7:0] CONST_HI = {5'b0, DEVSEL_TIMING, 1'b0};

    logic unused_const;
    assign unused_const = ^(set_in & ~W1C_MASK) ^ ^(wdata & ~W1C_MASK);

    for (genvar i = 0; i < 8; i++) begin : g_bit
        if (W1C_MASK[i]) begin : g_sticky
            logic q;
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= (q & ~(clr_en & wdata[i])) | set_in[i];
            end
            assign stat_hi[i] = q;

            // R10: an event is never lost to a simultaneous clear
            p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
                set_in[i] |=> stat_hi[i]);
            // R9: software cannot set a bit
            p_no_sw_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (!stat_hi[i] && !set_in[i]) |=> !stat_hi[i]);
            // R9: clearing write without event empties the bit
            p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_en && wdata[i] && !set_in[i]) |=> !stat_hi[i]);
        end else begin : g_const
            assign stat_hi[i] = CONST_HI[i];
        end
    end
endmodule

// File: rtl/pci_cs_pwr_fsm.sv
module pci_cs_pwr_fsm
    import pci_cs_pkg::*;
#(
    parameter int              MSG_W         = 16,
    parameter logic [MSG_W-1:0] SHUTDOWN_CODE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spc_en,
    input  logic             sc_valid,
    input  logic [MSG_W-1:0] sc_msg,
    output logic             low_power_req
);
    pwr_state_e state_q, state_d;
    logic       shutdown_hit;

    assign shutdown_hit = sc_valid && (sc_msg == SHUTDOWN_CODE) && spc_en;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PWR_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d       = state_q;
        low_power_req = 1'b0;
        unique case (state_q)
            PWR_ACTIVE: begin
                if (shutdown_hit) state_d = PWR_LOW;  // shutdown accepted
            end
            PWR_LOW: begin
                low_power_req = 1'b1;
            end
            default: state_d = PWR_ACTIVE;
        endcase
    end

    // R12: low power is held until reset
    p_lowpwr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_LOW) |=> (state_q == PWR_LOW));
    // R12: no entry without the special-cycle enable
    p_entry_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_ACTIVE && !spc_en) |=> (state_q == PWR_ACTIVE));
endmodule

// File: rtl/pci_cmdstat_regs.sv
module pci_cmdstat_regs
    import pci_cs_pkg::*;
#(
    parameter logic [1:0] DEVSEL_TIMING = 2'b01,
    parameter logic       FAST_B2B_CAP  = 1'b1,
    parameter int         MSG_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [3:0]       cfg_be,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             ev_perr,
    input  logic             ev_serr_req,
    input  logic             ev_mabort_rcv,
    input  logic             ev_tabort_rcv,
    input  logic             ev_tabort_sig,
    input  logic             ev_dperr_master,
    input  logic             sc_valid,
    input  logic [MSG_W-1:0] sc_msg,
    output logic             spcyc_en,
    output logic             mwi_en,
    output logic             perr_resp_en,
    output logic             serr_en,
    output logic             perr_out,
    output logic             serr_out,
    output logic             low_power_req
);
    logic [15:0] cmd;
    logic [7:0]  stat_hi;
    logic [7:0]  set_vec;
    logic [15:0] status;
    logic        unused_in;

    assign unused_in = ^{cfg_wdata[23:16], cfg_be[2]};

    pci_cs_cmd_reg u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .be    (cfg_be[1:0]),
        .wdata (cfg_wdata[15:0]),
        .cmd   (cmd)
    );

    assign spcyc_en     = cmd[CMD_SPCYC];
    assign mwi_en       = cmd[CMD_MWI];
    assign perr_resp_en = cmd[CMD_PERR];
    assign serr_en      = cmd[CMD_SERR];
    assign perr_out     = ev_perr & perr_resp_en;
    assign serr_out     = ev_serr_req & serr_en;

    always_comb begin
        set_vec         = '0;
        set_vec[SH_DPE] = ev_perr;
        set_vec[SH_SSE] = serr_out;
        set_vec[SH_RMA] = ev_mabort_rcv;
        set_vec[SH_RTA] = ev_tabort_rcv;
        set_vec[SH_STA] = ev_tabort_sig;
        set_vec[SH_DPD] = ev_dperr_master & perr_resp_en;
    end

    pci_cs_status_reg #(
        .DEVSEL_TIMING (DEVSEL_TIMING)
    ) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (cfg_wr & cfg_be[3]),
        .wdata   (cfg_wdata[31:24]),
        .set_in  (set_vec),
        .stat_hi (stat_hi)
    );

    assign status    = {stat_hi, FAST_B2B_CAP, 7'b0};
    assign cfg_rdata = {status, cmd};

    pci_cs_pwr_fsm #(
        .MSG_W         (MSG_W),
        .SHUTDOWN_CODE ('0)
    ) u_pwr (
        .clk           (clk),
        .rst_n         (rst_n),
        .spc_en        (spcyc_en),
        .sc_valid      (sc_valid),
        .sc_msg        (sc_msg),
        .low_power_req (low_power_req)
    );

    // R6: data parity bit cannot rise while parity response is off
    p_dpd_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!perr_resp_en && !cfg_rdata[24]) |=> !cfg_rdata[24]);
    // R7: system-error bit cannot rise while drive is disabled
    p_sse_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!serr_en && !cfg_rdata[30]) |=> !cfg_rdata[30]);
    // R5: detected parity is recorded regardless of response enable
    p_dpe_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_perr |=> cfg_rdata[31]);
    // R11: read-only status fields stay at their constants
    p_const_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[26:25] == DEVSEL_TIMING) && (cfg_rdata[23] == FAST_B2B_CAP)
        && (cfg_rdata[22:16] == 7'd0));
endmodule

// File: tb/tb_pci_cmdstat_regs.sv
module tb_pci_cmdstat_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [5:0]  ev = '0;  // [0] perr [1] serr_req [2] mabort_rcv [3] tabort_rcv [4] tabort_sig [5] dperr_master
    logic        sc_valid = 1'b0;
    logic [15:0] sc_msg = '0;
    logic spcyc_en, mwi_en, perr_resp_en, serr_en, perr_out, serr_out, low_power_req;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [15:0] STAT_CONST = 16'h0280;
    localparam logic [15:0] STAT_W1C   = 16'hF900;

    logic [15:0] exp_cmd;
    logic [15:0] exp_stat;
    logic        exp_lp;

    always #4 clk = ~clk;

    pci_cmdstat_regs dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ev_perr(ev[0]), .ev_serr_req(ev[1]), .ev_mabort_rcv(ev[2]),
        .ev_tabort_rcv(ev[3]), .ev_tabort_sig(ev[4]), .ev_dperr_master(ev[5]),
        .sc_valid(sc_valid), .sc_msg(sc_msg),
        .spcyc_en(spcyc_en), .mwi_en(mwi_en), .perr_resp_en(perr_resp_en),
        .serr_en(serr_en), .perr_out(perr_out), .serr_out(serr_out),
        .low_power_req(low_power_req)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R2 rdata"}, cfg_rdata, {exp_stat, exp_cmd});
        chk({tag, " R4 enables"}, {28'd0, spcyc_en, mwi_en, perr_resp_en, serr_en},
            {28'd0, exp_cmd[3], exp_cmd[4], exp_cmd[6], exp_cmd[8]});
        chk({tag, " R12 lowpower"}, {31'd0, low_power_req}, {31'd0, exp_lp});
    endtask

    // one bus cycle: drive at negedge, check gated outputs, check registers after the edge
    task automatic step(input string tag, input logic wr, input logic [3:0] be,
                        input logic [31:0] wd, input logic [5:0] evv,
                        input logic scv, input logic [15:0] msg);
        logic [15:0] setv, clr, mask;
        @(negedge clk);
        cfg_wr = wr; cfg_be = be; cfg_wdata = wd; ev = evv; sc_valid = scv; sc_msg = msg;
        #1;
        chk({tag, " R5 perr_out"}, {31'd0, perr_out}, {31'd0, evv[0] & exp_cmd[6]});
        chk({tag, " R7 serr_out"}, {31'd0, serr_out}, {31'd0, evv[1] & exp_cmd[8]});
        setv = '0;
        setv[15] = evv[0];
        setv[14] = evv[1] & exp_cmd[8];
        setv[13] = evv[2];
        setv[12] = evv[3];
        setv[11] = evv[4];
        setv[8]  = evv[5] & exp_cmd[6];
        clr = (wr && be[3]) ? (wd[31:16] & STAT_W1C) : 16'h0;
        exp_stat = (exp_stat & ~clr) | setv;
        if (scv && msg == 16'h0000 && exp_cmd[3]) exp_lp = 1'b1;
        mask = (be[0] ? 16'h0058 : 16'h0) | (be[1] ? 16'h0100 : 16'h0);
        if (wr) exp_cmd = (exp_cmd & ~mask) | (wd[15:0] & mask);
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0; ev = '0; sc_valid = 1'b0; sc_msg = '0;
        check_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_cmd = 16'h0; exp_stat = STAT_CONST; exp_lp = 1'b0;
        chk("R1 reset rdata", cfg_rdata, {STAT_CONST, 16'h0000});
        chk("R1 reset lowpower", {31'd0, low_power_req}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] pats [4];
        pats[0] = 16'hFFFF; pats[1] = 16'h0000; pats[2] = 16'h5555; pats[3] = 16'hAAAA;
        do_reset();

        // R2 R3 R4: byte enables x data patterns on the command half
        for (int b = 0; b < 16; b++)
            for (int p = 0; p < 4; p++)
                step("R3 cmd sweep", 1'b1, b[3:0], {16'h0000, pats[p]}, 6'd0, 1'b0, 16'h0);

        // R5 R6 R7 R8 R10: every event combination under every gating setting
        for (int g = 0; g < 4; g++) begin
            step("R2 gate setup", 1'b1, 4'b0011, {16'h0, 7'd0, g[1], 1'b0, g[0], 6'd0}, 6'd0, 1'b0, 16'h0);
            for (int e = 0; e < 64; e++) begin
                step("R9 clear all", 1'b1, 4'b1000, 32'hFFFF_0000, 6'd0, 1'b0, 16'h0);
                step("R8 event sweep", 1'b0, 4'b0000, 32'h0, e[5:0], 1'b0, 16'h0);
            end
        end

        // R9: single-bit clear, zero data, top byte disabled
        step("R8 fill", 1'b0, 4'b0, 32'h0, 6'b111111, 1'b0, 16'h0);
        step("R9 no be3", 1'b1, 4'b0111, 32'hFFFF_0000, 6'd0, 1'b0, 16'h0);
        step("R9 zero data", 1'b1, 4'b1000, 32'h0000_0000, 6'd0, 1'b0, 16'h0);
        step("R9 clear bit13", 1'b1, 4'b1000, 32'h2000_0000, 6'd0, 1'b0, 16'h0);
        step("R11 readonly write", 1'b1, 4'b1100, 32'h06FF_0000, 6'd0, 1'b0, 16'h0);
        // R10: clear and event on the same cycle
        step("R10 set wins", 1'b1, 4'b1000, 32'hFFFF_0000, 6'b010001, 1'b0, 16'h0);
        step("R9 clear rest", 1'b1, 4'b1000, 32'hFFFF_0000, 6'd0, 1'b0, 16'h0);

        // R12: special cycles
        step("R12 spc off", 1'b1, 4'b0001, 32'h0, 6'd0, 1'b0, 16'h0);
        step("R12 shutdown ignored", 1'b0, 4'b0, 32'h0, 6'd0, 1'b1, 16'h0000);
        step("R12 spc on", 1'b1, 4'b0001, 32'h0000_0008, 6'd0, 1'b0, 16'h0);
        for (int m = 1; m <= 8; m++)
            step("R12 other msg", 1'b0, 4'b0, 32'h0, 6'd0, 1'b1, m[15:0]);
        step("R12 shutdown msg", 1'b0, 4'b0, 32'h0, 6'd0, 1'b1, 16'h0000);
        step("R12 hold after cmd clear", 1'b1, 4'b0011, 32'h0, 6'd0, 1'b0, 16'h0);
        step("R12 hold idle", 1'b0, 4'b0, 32'h0, 6'd0, 1'b0, 16'h0);

        // R1: reset again from a busy state
        step("R1 busy", 1'b1, 4'b0011, 32'h0000_FFFF, 6'b111111, 1'b0, 16'h0);
        do_reset();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule